// File: doc/BRIEF.md
# Hierarchical Delay Code Stepper

This block holds the delay setting of one data lane as four nested fields: a phase step (0 to 6), a tap count whose upper limit depends on the selected memory clock, a clock-delay count (0 to 2) and a single coarse bit. Each increment request moves the setting one fine step forward. The phase field rolls over into the tap field, the tap field into the clock-delay field, and the clock-delay field into the coarse bit. A training engine uses this counter to sweep a lane across its delay range. It can also load a starting value.

Every time the setting changes, the block recomputes two bypass-control bits, an enable and a select. It does this by comparing the new tap and phase against two packed thresholds chosen by the clock speed. The bypass bits are registered in the same cycle as the fields, so the outputs always match each other. When an increment arrives at the top of the range, the setting is left unchanged and a saturation flag is raised.

Top module: `dly_code_stepper`

## Requirements
- R1: After reset, phase, tap, clock-delay and coarse are all 0. The bypass enable and select are both 1, and saturation is 0.
- R2: An increment with phase below 6 adds 1 to phase and leaves the other fields unchanged.
- R3: An increment with phase at 6 or above and tap below the tap limit sets phase to 0 and adds 1 to tap.
- R4: The tap limit is 12 for speed code 0, 10 for speed code 1 and 13 for speed code 2. Code 3 behaves like code 0. Stepping from an all-zero setting to the top of the range therefore takes 7*(limit+1)*3*2-1 increments.
- R5: An increment with phase at 6 or above, tap at or above the limit and clock-delay below 2 clears phase and tap and adds 1 to clock-delay.
- R6: An increment with phase, tap and clock-delay all at or above their limits and coarse at 0 clears the three lower fields and sets coarse.
- R7: An increment at the top of the range (coarse 1, with every other field at or above its limit) leaves all fields and bypass bits unchanged. It sets saturation in the next cycle, and saturation stays set until a load.
- R8: A load places the load value into the fields in the next cycle and clears saturation.
- R9: When load and increment arrive in the same cycle, the load wins and no step is taken.
- R10: Each speed code has a tap threshold and a phase threshold of 8 bits each: code 0 uses 0xA3/0x32, code 1 uses 0x82/0x76, code 2 uses 0xB3/0x46. Enable=1 and select=1 when the tap is below the low tap nibble, or equals it while the phase is below the low phase nibble. Otherwise enable=0 and select=0 when the same test passes against the high nibbles. In every other case enable=1 and select=0.
- R11: The bypass bits are registered together with the fields, computed from the new setting. They do not change in a cycle with no load and no increment, even if the speed code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 2 | Memory clock speed code |
| load_i | input | 1 | Load strobe |
| inc_i | input | 1 | Increment strobe |
| ld_phase_i | input | 3 | Load value, phase field |
| ld_tap_i | input | 4 | Load value, tap field |
| ld_cdly_i | input | 2 | Load value, clock-delay field |
| ld_coarse_i | input | 1 | Load value, coarse bit |
| phase_o | output | 3 | Current phase step |
| tap_o | output | 4 | Current tap count |
| cdly_o | output | 2 | Current clock-delay count |
| coarse_o | output | 1 | Current coarse bit |
| byp_en_o | output | 1 | Bypass enable |
| byp_sel_o | output | 1 | Bypass select |
| sat_o | output | 1 | Saturation flag |

## Verification
Load and increment can fall in the same cycle. This happens often in the random phase of the bench and is also forced deliberately while the counter sits at saturation. The outputs are judged against a reference model in which the load wins, no step is taken, and saturation is cleared. An increment can also land on the saturated setting in the same cycle as a change of speed code. The bench checks that the refused step leaves both the fields and the bypass bits untouched.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;
  localparam int PH_W  = 3;
  localparam int TAP_W = 4;
  localparam int CD_W  = 2;
  localparam int SPD_W = 2;
  localparam int THR_W = 8;

  localparam logic [PH_W-1:0] PH_MAX = 3'd6;
  localparam logic [CD_W-1:0] CD_MAX = 2'd2;

  typedef struct packed {
    logic             coarse;
    logic [CD_W-1:0]  cdly;
    logic [TAP_W-1:0] tap;
    logic [PH_W-1:0]  phase;
  } dly_code_t;
endpackage

// File: rtl/dly_speed_limits.sv
module dly_speed_limits
  import dly_step_pkg::*;
#(
  parameter logic [TAP_W-1:0] TAP_MAX_0 = 4'd12,
  parameter logic [TAP_W-1:0] TAP_MAX_1 = 4'd10,
  parameter logic [TAP_W-1:0] TAP_MAX_2 = 4'd13,
  parameter logic [THR_W-1:0] TAP_THR_0 = 8'hA3,
  parameter logic [THR_W-1:0] PH_THR_0  = 8'h32,
  parameter logic [THR_W-1:0] TAP_THR_1 = 8'h82,
  parameter logic [THR_W-1:0] PH_THR_1  = 8'h76,
  parameter logic [THR_W-1:0] TAP_THR_2 = 8'hB3,
  parameter logic [THR_W-1:0] PH_THR_2  = 8'h46
) (
  input  logic [SPD_W-1:0] speed_i,
  output logic [TAP_W-1:0] tap_max_o,
  output logic [THR_W-1:0] tap_thr_o,
  output logic [THR_W-1:0] ph_thr_o
);
  // unused code 3 falls back to the slowest speed
  always_comb begin
    unique case (speed_i)
      2'd1: begin tap_max_o = TAP_MAX_1; tap_thr_o = TAP_THR_1; ph_thr_o = PH_THR_1; end
      2'd2: begin tap_max_o = TAP_MAX_2; tap_thr_o = TAP_THR_2; ph_thr_o = PH_THR_2; end
      default: begin tap_max_o = TAP_MAX_0; tap_thr_o = TAP_THR_0; ph_thr_o = PH_THR_0; end
    endcase
  end
endmodule

// File: rtl/dly_bypass_decode.sv
module dly_bypass_decode
  import dly_step_pkg::*;
(
  input  logic [TAP_W-1:0] tap_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [THR_W-1:0] tap_thr_i,
  input  logic [THR_W-1:0] ph_thr_i,
  output logic             en_o,
  output logic             sel_o
);
  localparam int NIB = THR_W / 2;

  logic [NIB-1:0] tap_lo, tap_hi, ph_lo, ph_hi;
  logic [NIB-1:0] tap_x, ph_x;
  logic           below_lo, below_hi;

  assign tap_lo = tap_thr_i[NIB-1:0];
  assign tap_hi = tap_thr_i[THR_W-1:NIB];
  assign ph_lo  = ph_thr_i[NIB-1:0];
  assign ph_hi  = ph_thr_i[THR_W-1:NIB];
  assign tap_x  = NIB'(tap_i);
  assign ph_x   = NIB'(phase_i);

  assign below_lo = (tap_x < tap_lo) || ((tap_x == tap_lo) && (ph_x < ph_lo));
  assign below_hi = (tap_x < tap_hi) || ((tap_x == tap_hi) && (ph_x < ph_hi));

  always_comb begin
    if (below_lo)      begin en_o = 1'b1; sel_o = 1'b1; end
    else if (below_hi) begin en_o = 1'b0; sel_o = 1'b0; end
    else               begin en_o = 1'b1; sel_o = 1'b0; end
  end
endmodule

// File: rtl/dly_step_next.sv
module dly_step_next
  import dly_step_pkg::*;
(
  input  dly_code_t        cur_i,
  input  logic [TAP_W-1:0] tap_max_i,
  output dly_code_t        nxt_o,
  output logic             sat_o
);
  always_comb begin
    nxt_o = cur_i;
    sat_o = 1'b0;
    if (cur_i.phase < PH_MAX) begin
      nxt_o.phase = cur_i.phase + 1'b1;
    end else if (cur_i.tap < tap_max_i) begin
      nxt_o.phase = '0;
      nxt_o.tap   = cur_i.tap + 1'b1;
    end else if (cur_i.cdly < CD_MAX) begin
      nxt_o.phase = '0;
      nxt_o.tap   = '0;
      nxt_o.cdly  = cur_i.cdly + 1'b1;
    end else if (!cur_i.coarse) begin
      nxt_o.phase  = '0;
      nxt_o.tap    = '0;
      nxt_o.cdly   = '0;
      nxt_o.coarse = 1'b1;
    end else begin
      sat_o = 1'b1;
    end
  end
endmodule

// File: rtl/dly_code_stepper.sv
module dly_code_stepper
  import dly_step_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SPD_W-1:0] speed_i,
  input  logic             load_i,
  input  logic             inc_i,
  input  logic [PH_W-1:0]  ld_phase_i,
  input  logic [TAP_W-1:0] ld_tap_i,
  input  logic [CD_W-1:0]  ld_cdly_i,
  input  logic             ld_coarse_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [CD_W-1:0]  cdly_o,
  output logic             coarse_o,
  output logic             byp_en_o,
  output logic             byp_sel_o,
  output logic             sat_o
);
  dly_code_t        cur_q, step_d, new_d;
  logic [TAP_W-1:0] tap_max;
  logic [THR_W-1:0] tap_thr, ph_thr;
  logic             at_top, en_d, sel_d, en_q, sel_q, sat_q;
  logic             upd;

  dly_speed_limits u_lim (
    .speed_i   (speed_i),
    .tap_max_o (tap_max),
    .tap_thr_o (tap_thr),
    .ph_thr_o  (ph_thr)
  );

  dly_step_next u_step (
    .cur_i     (cur_q),
    .tap_max_i (tap_max),
    .nxt_o     (step_d),
    .sat_o     (at_top)
  );

  always_comb begin
    if (load_i) new_d = '{coarse: ld_coarse_i, cdly: ld_cdly_i, tap: ld_tap_i, phase: ld_phase_i};
    else        new_d = step_d;
  end

  dly_bypass_decode u_byp (
    .tap_i     (new_d.tap),
    .phase_i   (new_d.phase),
    .tap_thr_i (tap_thr),
    .ph_thr_i  (ph_thr),
    .en_o      (en_d),
    .sel_o     (sel_d)
  );

  // a refused step leaves fields and bypass bits alone
  assign upd = load_i || (inc_i && !at_top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      en_q  <= 1'b1;
      sel_q <= 1'b1;
      sat_q <= 1'b0;
    end else begin
      if (upd) begin
        cur_q <= new_d;
        en_q  <= en_d;
        sel_q <= sel_d;
      end
      if (load_i)              sat_q <= 1'b0;
      else if (inc_i && at_top) sat_q <= 1'b1;
    end
  end

  assign phase_o   = cur_q.phase;
  assign tap_o     = cur_q.tap;
  assign cdly_o    = cur_q.cdly;
  assign coarse_o  = cur_q.coarse;
  assign byp_en_o  = en_q;
  assign byp_sel_o = sel_q;
  assign sat_o     = sat_q;

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && phase_o < PH_MAX) |=>
      (phase_o == $past(phase_o) + 1'b1) && $stable(tap_o) && $stable(cdly_o) && $stable(coarse_o));

  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && coarse_o && cdly_o >= CD_MAX && tap_o >= tap_max && phase_o >= PH_MAX) |=>
      sat_o && $stable(phase_o) && $stable(tap_o) && $stable(cdly_o) && $stable(byp_en_o) && $stable(byp_sel_o));

  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !sat_o && phase_o == $past(ld_phase_i) && tap_o == $past(ld_tap_i)
               && cdly_o == $past(ld_cdly_i) && coarse_o == $past(ld_coarse_i));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(byp_en_o) && $stable(byp_sel_o) && $stable(phase_o) && $stable(tap_o));

  p_code_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byp_sel_o && !byp_en_o));
endmodule

// File: tb/dly_code_stepper_test.sv
module dly_code_stepper_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed = 2'd0;
  logic       load = 1'b0, inc = 1'b0;
  logic [2:0] ld_ph = '0;
  logic [3:0] ld_tap = '0;
  logic [1:0] ld_cd = '0;
  logic       ld_co = 1'b0;
  logic [2:0] ph_o;
  logic [3:0] tap_o;
  logic [1:0] cd_o;
  logic       co_o, en_o, sel_o, sat_o;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [2:0] m_ph;
  logic [3:0] m_tap;
  logic [1:0] m_cd;
  logic       m_co, m_en, m_sel, m_sat;

  always #4 clk = ~clk;

  dly_code_stepper uut (
    .clk_i(clk), .rst_ni(rst_n), .speed_i(speed), .load_i(load), .inc_i(inc),
    .ld_phase_i(ld_ph), .ld_tap_i(ld_tap), .ld_cdly_i(ld_cd), .ld_coarse_i(ld_co),
    .phase_o(ph_o), .tap_o(tap_o), .cdly_o(cd_o), .coarse_o(co_o),
    .byp_en_o(en_o), .byp_sel_o(sel_o), .sat_o(sat_o)
  );

  function automatic int lim_of(input logic [1:0] s);
    return (s == 2'd1) ? 10 : (s == 2'd2) ? 13 : 12;
  endfunction

  function automatic logic [1:0] byp_of(input logic [1:0] s, input int tp, input int ph);
    int tt, pt;
    tt = (s == 2'd1) ? 'h82 : (s == 2'd2) ? 'hB3 : 'hA3;
    pt = (s == 2'd1) ? 'h76 : (s == 2'd2) ? 'h46 : 'h32;
    if (tp < (tt & 15) || (tp == (tt & 15) && ph < (pt & 15))) return 2'b11;
    if (tp < (tt >> 4) || (tp == (tt >> 4) && ph < (pt >> 4))) return 2'b00;
    return 2'b10;
  endfunction

  function automatic bit model_top(input logic [1:0] s);
    return m_co && m_cd >= 2 && int'(m_tap) >= lim_of(s) && m_ph >= 6;
  endfunction

  task automatic model_step(input logic [1:0] s, input bit ld, input bit ic);
    logic [1:0] b;
    if (ld) begin
      m_ph = ld_ph; m_tap = ld_tap; m_cd = ld_cd; m_co = ld_co; m_sat = 1'b0;
    end else if (ic) begin
      if (model_top(s)) begin m_sat = 1'b1; return; end
      if (m_ph < 6) m_ph = m_ph + 1;
      else if (int'(m_tap) < lim_of(s)) begin m_ph = 0; m_tap = m_tap + 1; end
      else if (m_cd < 2) begin m_ph = 0; m_tap = 0; m_cd = m_cd + 1; end
      else begin m_ph = 0; m_tap = 0; m_cd = 0; m_co = 1; end
    end else return;
    b = byp_of(s, int'(m_tap), int'(m_ph));
    m_en = b[1]; m_sel = b[0];
  endtask

  task automatic check(input string req);
    n_chk++;
    if ({ph_o, tap_o, cd_o, co_o, en_o, sel_o, sat_o} !==
        {m_ph, m_tap, m_cd, m_co, m_en, m_sel, m_sat}) begin
      n_bad++;
      $display("FAIL %s: got ph=%0d tap=%0d cd=%0d co=%0d en=%0d sel=%0d sat=%0d exp ph=%0d tap=%0d cd=%0d co=%0d en=%0d sel=%0d sat=%0d",
               req, ph_o, tap_o, cd_o, co_o, en_o, sel_o, sat_o,
               m_ph, m_tap, m_cd, m_co, m_en, m_sel, m_sat);
    end
  endtask

  // drive at negedge, clock it, update model, compare at next negedge
  task automatic cyc(input bit ld, input bit ic);
    load = ld; inc = ic;
    @(posedge clk);
    model_step(speed, ld, ic);
    @(negedge clk);
    load = 1'b0; inc = 1'b0;
  endtask

  task automatic do_load(input int ph, input int tp, input int cd, input int co);
    ld_ph = 3'(ph); ld_tap = 4'(tp); ld_cd = 2'(cd); ld_co = 1'(co);
    cyc(1'b1, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int steps;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_ph = 0; m_tap = 0; m_cd = 0; m_co = 0; m_en = 1; m_sel = 1; m_sat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    // R2 / R3 / R5 / R6 directed carries at speed 0
    do_load(2, 5, 0, 0); cyc(0, 1); check("R2 phase step");
    do_load(6, 5, 1, 0); cyc(0, 1); check("R3 phase carry");
    do_load(6, 12, 1, 0); cyc(0, 1); check("R5 tap carry");
    do_load(6, 12, 2, 0); cyc(0, 1); check("R6 coarse carry");

    // R4: full sweep per speed code
    for (int s = 0; s < 4; s++) begin
      speed = 2'(s);
      do_load(0, 0, 0, 0);
      steps = 0;
      while (!sat_o && steps < 1000) begin
        cyc(0, 1);
        if (!m_sat) steps++;
      end
      n_chk++;
      if (steps != 7 * (lim_of(2'(s)) + 1) * 6 - 1) begin
        n_bad++;
        $display("FAIL R4 sweep length speed %0d: got %0d exp %0d", s, steps,
                 7 * (lim_of(2'(s)) + 1) * 6 - 1);
      end
      check("R7 saturated");
      cyc(0, 1); check("R7 sticky");
    end

    // R9: load with increment while saturated, also with speed change
    speed = 2'd2;
    ld_ph = 1; ld_tap = 4; ld_cd = 1; ld_co = 0;
    cyc(1, 1); check("R9 load wins");
    do_load(6, 13, 2, 1);
    speed = 2'd0; cyc(0, 1); check("R7 refused on speed change");
    do_load(3, 3, 0, 0); check("R8 load clears sat");

    // R10 bypass thresholds at speed 0
    speed = 2'd0;
    do_load(1, 2, 0, 0); check("R10 below low tap");
    do_load(1, 3, 0, 0); check("R10 low tap, low phase");
    do_load(2, 3, 0, 0); check("R10 past low pair");
    do_load(2, 10, 0, 0); check("R10 high tap, low phase");
    do_load(3, 10, 0, 0); check("R10 past high pair");
    speed = 2'd1; do_load(6, 8, 0, 0); check("R10 speed1 high tap");
    speed = 2'd1; do_load(5, 2, 0, 0); check("R10 speed1 low tap");
    speed = 2'd2; do_load(5, 4, 0, 0); check("R10 speed2 high tap");

    // R11: idle with speed change keeps bypass bits
    speed = 2'd1; cyc(0, 0); check("R11 idle hold");
    speed = 2'd2; cyc(0, 0); check("R11 idle hold 2");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit ld, ic;
      if ($urandom_range(0, 19) == 0) speed = 2'($urandom_range(0, 3));
      ld = ($urandom_range(0, 9) == 0);
      ic = ($urandom_range(0, 9) < 7);
      ld_ph = 3'($urandom); ld_tap = 4'($urandom); ld_cd = 2'($urandom); ld_co = 1'($urandom);
      cyc(ld, ic);
      if (ld && ic) check("R9 random");
      else if (ld) check("R8 random");
      else if (ic) check("R2 R3 R5 R6 R7 R10 random");
      else check("R11 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule